// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns characters into asynchronous serial frames on one transmit line. A one-entry holding buffer takes each character through a valid/ready handshake. A frame sequencer then drives the line: a low start bit, the data bits least significant first, and a stop interval at the high level. The stop interval can last half a bit, one bit, one and a half bits or two bits. A character is eight or nine bits wide. When parity is on, the top data slot carries the parity bit in place of the top payload bit, so the frame keeps its length.

Each buffer entry also carries a kind code. With it, software can queue a full-length idle frame (line high) or a full-length break frame (line low) between characters. A bit timer counts input clocks in half-bit steps. The bit period is the divider value times 16 clocks, or times 8 when the fast oversampling select is set. An optional clear-to-send gate holds off the start of each new frame until the peer is ready.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx` is 1, `wr_ready` is 1 and `tx_done` is 0.
- R2: `tx` stays 1 while no frame is in progress, and no frame starts while `tx_en` is 0.
- R3: A data frame (`wr_kind`=00) starts one clock after the write is accepted. It drives a 0 start bit for one bit period, then the data bits least significant first, one bit period each, then 1 for the stop interval. With `word9`=0 the frame carries `wr_data[7:0]`.
- R4: With `word9`=1 the frame carries nine data bits, `wr_data[8:0]`.
- R5: With `par_en`=1 the last data slot (slot 8 when `word9`=0, slot 9 when `word9`=1) carries parity over the lower payload bits. The parity is even when `par_odd`=0 and odd when `par_odd`=1. The replaced top data bit is not sent.
- R6: `stop_sel` sets the stop interval: 00 = 1 bit, 01 = 0.5 bit, 10 = 2 bits, 11 = 1.5 bits. A half bit lasts half a bit period.
- R7: The bit period is max(`div_val`,1) × 16 clocks when `ovs8`=0 and max(`div_val`,1) × 8 clocks when `ovs8`=1.
- R8: `wr_kind`=01 queues an idle frame, which holds `tx` at 1 for one whole frame length. `wr_kind`=10 or 11 queues a break frame, which holds `tx` at 0 for one whole frame length. Neither has a start bit.
- R9: With `flow_en`=1, a queued frame starts only in a cycle where `cts_n` is 0.
- R10: `wr_ready` is 0 while the buffer holds a character. A character written during a frame starts on the clock edge that ends that frame, with no idle gap.
- R11: `tx_done` goes to 1 on the edge that ends a frame if the buffer is then empty. It goes back to 0 when a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; gates the start of new frames |
| div_val | input | DIV_W | Bit-rate divider (0 is treated as 1) |
| ovs8 | input | 1 | 1: 8 clocks per divider unit; 0: 16 clocks |
| word9 | input | 1 | 1: nine data bits; 0: eight |
| par_en | input | 1 | Parity replaces the top data slot |
| par_odd | input | 1 | 1: odd parity; 0: even parity |
| stop_sel | input | 2 | Stop interval code |
| flow_en | input | 1 | Enable the clear-to-send gate |
| cts_n | input | 1 | Active-low clear to send |
| wr_valid | input | 1 | Write request |
| wr_kind | input | 2 | 00 data, 01 idle frame, 1x break frame |
| wr_data | input | 9 | Character to send |
| wr_ready | output | 1 | Buffer can accept a write |
| tx | output | 1 | Serial line |
| tx_done | output | 1 | Last frame finished and buffer empty |

## Verification
The bench samples `tx` in the middle of every half-bit slot of each frame. A timer that is off by one clock, or one that ignores the zero-divider rule or the oversampling select, drifts across the frame and lands a sample in the wrong slot. The half-bit stop codes are checked directly, because a design that rounds 0.5 or 1.5 stop bits to whole bits would show the next frame or the idle level one slot too late or too early. Parity frames are checked at both word lengths, since appending the parity bit instead of replacing the top data bit shifts the stop interval by a bit. Back-to-back frames are checked for a missing idle gap, a frame held off by clear-to-send or by the enable is checked for not starting early, and break frames are checked for a stray start bit and for a full low length.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers for the frame transmitter.
// Assumes a character is at most nine bits wide.
package uart_tx_pkg;

    typedef enum logic [1:0] {
        K_DATA  = 2'b00,
        K_IDLE  = 2'b01,
        K_BREAK = 2'b10
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e kind;
        logic        nine;
        logic [8:0]  bits;
        logic [4:0]  last_h;
    } frame_t;

    // Maps the write-side kind code to a frame kind; 11 counts as a break.
    function automatic frame_kind_e decode_kind(input logic [1:0] code);
        case (code)
            2'b00:   decode_kind = K_DATA;
            2'b01:   decode_kind = K_IDLE;
            default: decode_kind = K_BREAK;
        endcase
    endfunction

    // Stop interval in half-bit units.
    function automatic logic [2:0] stop_halves(input logic [1:0] sel);
        case (sel)
            2'b00:   stop_halves = 3'd2;
            2'b01:   stop_halves = 3'd1;
            2'b10:   stop_halves = 3'd4;
            default: stop_halves = 3'd3;
        endcase
    endfunction

    // Line level for half-bit index h of frame f.
    function automatic logic line_level(input frame_t f, input logic [4:0] h);
        logic [3:0] slot;
        logic [3:0] n;
        slot = h[4:1];
        n    = f.nine ? 4'd9 : 4'd8;
        case (f.kind)
            K_IDLE:  line_level = 1'b1;
            K_BREAK: line_level = 1'b0;
            default: begin
                if (slot == 4'd0)
                    line_level = 1'b0;
                else if (slot <= n)
                    line_level = f.bits[slot - 4'd1];
                else
                    line_level = 1'b1;
            end
        endcase
    endfunction

endpackage

// File: rtl/tx_hold_buffer.sv
// One-entry holding register between the write port and the sequencer.
// Assumes the sequencer raises take only while full is set.
module tx_hold_buffer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [1:0] wr_kind,
    input  logic [8:0] wr_data,
    output logic       wr_ready,
    output logic       wr_accept,
    input  logic       take,
    output logic       full,
    output logic [1:0] q_kind,
    output logic [8:0] q_data
);
    logic       full_q;
    logic [1:0] kind_q;
    logic [8:0] data_q;

    // Handshake: the buffer accepts a write only when it is empty.
    always_comb begin
        wr_ready  = !full_q;
        wr_accept = wr_valid && !full_q;
    end

    // Load on an accepted write, release when the sequencer takes the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            kind_q <= 2'b00;
            data_q <= 9'd0;
        end else if (wr_accept) begin
            full_q <= 1'b1;
            kind_q <= wr_kind;
            data_q <= wr_data;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign full   = full_q;
    assign q_kind = kind_q;
    assign q_data = data_q;

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take) |=> (full_q && $stable(data_q) && $stable(kind_q)));
    // R10
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> full_q);

endmodule

// File: rtl/tx_bit_timer.sv
// Half-bit timer: pulses half_tick once per half bit period while run is high.
// Assumes div and ovs8 stay stable while a frame is in progress.
module tx_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             ovs8,
    output logic             half_tick
);
    localparam int CNT_W = DIV_W + 3;

    logic [DIV_W-1:0] div_eff;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;

    // Half period = max(div,1) * 4 or * 8 clocks.
    always_comb begin
        div_eff   = (div == '0) ? DIV_W'(1) : div;
        limit     = ovs8 ? {1'b0, div_eff, 2'b00} : {div_eff, 3'b000};
        half_tick = run && (cnt_q == limit - CNT_W'(1));
    end

    // Count clocks inside the current half bit; held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || half_tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R7
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> !half_tick);
    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/tx_frame_pack.sv
// Builds the frame descriptor from a buffered entry and the live configuration.
// Purely combinational; the sequencer registers the result at frame start.
module tx_frame_pack
    import uart_tx_pkg::*;
(
    input  logic [1:0] kind_code,
    input  logic [8:0] data,
    input  logic       word9,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic [1:0] stop_sel,
    output frame_t     frame
);
    logic [3:0] n;
    logic       par;

    // Parity over the payload bits below the top slot, then place the bits.
    always_comb begin
        n   = word9 ? 4'd9 : 4'd8;
        par = par_odd;
        for (int i = 0; i < 9; i++) begin
            if (i < int'(n) - 1)
                par = par ^ data[i];
        end
        frame.bits = '0;
        for (int i = 0; i < 9; i++) begin
            if (i < int'(n) - 1)
                frame.bits[i] = data[i];
            else if (i == int'(n) - 1)
                frame.bits[i] = par_en ? par : data[i];
        end
        frame.kind   = decode_kind(kind_code);
        frame.nine   = word9;
        frame.last_h = 5'(2 * (int'(n) + 1) + int'(stop_halves(stop_sel)) - 1);
    end

endmodule

// File: rtl/tx_frame_seq.sv
// Frame sequencer: starts frames from the buffer, walks half-bit slots and
// drives the registered line level and the completion flag.
// Assumes half_tick comes from a timer run by busy.
module tx_frame_seq
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tx_en,
    input  logic   flow_en,
    input  logic   cts_n,
    input  logic   full,
    input  frame_t next_frame,
    input  logic   wr_accept,
    input  logic   half_tick,
    output logic   take,
    output logic   busy,
    output logic   tx,
    output logic   tx_done
);
    logic       busy_q, busy_d;
    logic [4:0] h_q, h_d;
    frame_t     frame_q, frame_d;
    logic       tx_q, tx_d;
    logic       done_q, done_d;
    logic       start_ok, frame_end, can_load;

    // Next-state decode: start, advance or finish a frame.
    always_comb begin
        start_ok  = tx_en && (!flow_en || !cts_n);
        frame_end = busy_q && half_tick && (h_q == frame_q.last_h);
        can_load  = full && start_ok && (!busy_q || frame_end);
        busy_d  = busy_q;
        h_d     = h_q;
        frame_d = frame_q;
        take    = 1'b0;
        if (can_load) begin
            busy_d  = 1'b1;
            h_d     = 5'd0;
            frame_d = next_frame;
            take    = 1'b1;
        end else if (frame_end) begin
            busy_d = 1'b0;
            h_d    = 5'd0;
        end else if (busy_q && half_tick) begin
            h_d = h_q + 5'd1;
        end
        tx_d   = busy_d ? line_level(frame_d, h_d) : 1'b1;
        done_d = done_q;
        if (frame_end && !full)
            done_d = 1'b1;
        if (wr_accept)
            done_d = 1'b0;
    end

    // State registers, including the registered line output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            h_q     <= 5'd0;
            frame_q <= '0;
            tx_q    <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            busy_q  <= busy_d;
            h_q     <= h_d;
            frame_q <= frame_d;
            tx_q    <= tx_d;
            done_q  <= done_d;
        end
    end

    assign busy    = busy_q;
    assign tx      = tx_q;
    assign tx_done = done_q;

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> tx_q);
    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && h_q < 5'd2 && frame_q.kind == K_DATA) |-> !tx_q);
    // R8
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && frame_q.kind == K_BREAK) |-> !tx_q);
    // R9
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(!flow_en || !cts_n));
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    // R6
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (h_q <= frame_q.last_h));

endmodule

// File: rtl/uart_frame_tx.sv
// Top level of the asynchronous frame transmitter: holding buffer, frame
// packer, half-bit timer and frame sequencer.
// Assumes configuration inputs change only while no frame is in progress.
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ovs8,
    input  logic             word9,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic [1:0]       stop_sel,
    input  logic             flow_en,
    input  logic             cts_n,
    input  logic             wr_valid,
    input  logic [1:0]       wr_kind,
    input  logic [8:0]       wr_data,
    output logic             wr_ready,
    output logic             tx,
    output logic             tx_done
);
    logic       wr_accept, take, full, busy, half_tick;
    logic [1:0] q_kind;
    logic [8:0] q_data;
    frame_t     next_frame;

    tx_hold_buffer u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_kind   (wr_kind),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .wr_accept (wr_accept),
        .take      (take),
        .full      (full),
        .q_kind    (q_kind),
        .q_data    (q_data)
    );

    tx_frame_pack u_pack (
        .kind_code (q_kind),
        .data      (q_data),
        .word9     (word9),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .stop_sel  (stop_sel),
        .frame     (next_frame)
    );

    tx_bit_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (div_val),
        .ovs8      (ovs8),
        .half_tick (half_tick)
    );

    tx_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .flow_en    (flow_en),
        .cts_n      (cts_n),
        .full       (full),
        .next_frame (next_frame),
        .wr_accept  (wr_accept),
        .half_tick  (half_tick),
        .take       (take),
        .busy       (busy),
        .tx         (tx),
        .tx_done    (tx_done)
    );

    // R10
    take_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

endmodule

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b1;
    logic [15:0] div_val = 16'd1;
    logic        ovs8 = 1'b0;
    logic        word9 = 1'b0;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic [1:0]  stop_sel = 2'b00;
    logic        flow_en = 1'b0;
    logic        cts_n = 1'b1;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_kind = 2'b00;
    logic [8:0]  wr_data = 9'd0;
    logic        wr_ready, tx, tx_done;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    uart_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .div_val(div_val),
        .ovs8(ovs8), .word9(word9), .par_en(par_en), .par_odd(par_odd),
        .stop_sel(stop_sel), .flow_en(flow_en), .cts_n(cts_n),
        .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_data(wr_data),
        .wr_ready(wr_ready), .tx(tx), .tx_done(tx_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int half_len();
        int d;
        d = (div_val == 16'd0) ? 1 : int'(div_val);
        return d * (ovs8 ? 4 : 8);
    endfunction

    function automatic int exp_halves(input logic [1:0] kind);
        int n;
        int s;
        n = word9 ? 9 : 8;
        case (stop_sel)
            2'b00: s = 2;
            2'b01: s = 1;
            2'b10: s = 4;
            default: s = 3;
        endcase
        if (kind == 2'b11) s = s;
        return 2 * (1 + n) + s;
    endfunction

    function automatic int exp_level(input logic [1:0] kind, input logic [8:0] d, input int k);
        int n;
        int slot;
        int pos;
        logic p;
        n = word9 ? 9 : 8;
        slot = k / 2;
        if (kind == 2'b01) return 1;
        if (kind[1]) return 0;
        if (slot == 0) return 0;
        if (slot > n) return 1;
        pos = slot - 1;
        if (par_en && pos == n - 1) begin
            p = par_odd;
            for (int i = 0; i < n - 1; i++) p = p ^ d[i];
            return int'(p);
        end
        return int'(d[pos]);
    endfunction

    // Write one entry; returns just after the negedge following acceptance.
    task automatic put(input logic [1:0] kind, input logic [8:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_kind  = kind;
        wr_data  = d;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R11", "done cleared by write", int'(tx_done), 0);
    endtask

    // Called just after the frame's start edge; samples every half-bit slot mid-way.
    task automatic run_frame(input logic [1:0] kind, input logic [8:0] d, input string req);
        int h;
        int nh;
        h  = half_len();
        nh = exp_halves(kind);
        for (int k = 0; k < nh; k++) begin
            repeat (h / 2) @(posedge clk);
            @(negedge clk);
            chk(req, $sformatf("tx half %0d", k), int'(tx), exp_level(kind, d, k));
            repeat (h - h / 2) @(posedge clk);
        end
    endtask

    task automatic single(input logic [1:0] kind, input logic [8:0] d, input string req);
        put(kind, d);
        @(posedge clk);
        run_frame(kind, d, req);
        @(negedge clk);
        chk("R11", "done after frame", int'(tx_done), 1);
        chk("R2", "line high after frame", int'(tx), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "tx after reset", int'(tx), 1);
        chk("R1", "ready after reset", int'(wr_ready), 1);
        chk("R1", "done after reset", int'(tx_done), 0);

        // R3 R7 basic eight-bit frame
        single(2'b00, 9'h0A5, "R3");
        // R7 fast oversampling, R6 two stop bits
        div_val = 16'd2; ovs8 = 1'b1; stop_sel = 2'b10;
        single(2'b00, 9'h13C, "R6");
        // R4 nine-bit word
        div_val = 16'd1; ovs8 = 1'b0; stop_sel = 2'b00; word9 = 1'b1;
        single(2'b00, 9'h1C3, "R4");
        // R5 odd parity nine-bit, even parity eight-bit
        par_en = 1'b1; par_odd = 1'b1;
        single(2'b00, 9'h1B7, "R5");
        word9 = 1'b0; par_odd = 1'b0;
        single(2'b00, 9'h0F3, "R5");
        single(2'b00, 9'h071, "R5");
        par_en = 1'b0;
        // R6 half and one-and-a-half stop bits
        stop_sel = 2'b01;
        single(2'b00, 9'h055, "R6");
        stop_sel = 2'b11;
        single(2'b00, 9'h0AA, "R6");
        // R7 zero divider acts as one
        div_val = 16'd0; stop_sel = 2'b00;
        single(2'b00, 9'h0C9, "R7");
        div_val = 16'd3; ovs8 = 1'b1;
        single(2'b00, 9'h036, "R7");
        div_val = 16'd1; ovs8 = 1'b0;
        // R8 idle and break frames
        single(2'b01, 9'h000, "R8");
        single(2'b10, 9'h1FF, "R8");
        word9 = 1'b1; stop_sel = 2'b11;
        single(2'b11, 9'h000, "R8");
        word9 = 1'b0; stop_sel = 2'b00;

        // R2 disabled transmitter holds the frame
        tx_en = 1'b0;
        put(2'b00, 9'h012);
        repeat (40) @(negedge clk);
        chk("R2", "no frame while disabled", int'(tx), 1);
        tx_en = 1'b1;
        @(posedge clk);
        run_frame(2'b00, 9'h012, "R2");
        @(negedge clk);
        chk("R11", "done after held frame", int'(tx_done), 1);

        // R9 clear-to-send gate
        flow_en = 1'b1; cts_n = 1'b1;
        put(2'b00, 9'h0E1);
        repeat (40) @(negedge clk);
        chk("R9", "no frame while cts high", int'(tx), 1);
        chk("R11", "done low while queued", int'(tx_done), 0);
        cts_n = 1'b0;
        @(posedge clk);
        run_frame(2'b00, 9'h0E1, "R9");
        @(negedge clk);
        flow_en = 1'b0; cts_n = 1'b1;

        // R10 back-to-back frames and ready low while full
        put(2'b00, 9'h03C);
        @(posedge clk);
        fork
            run_frame(2'b00, 9'h03C, "R10");
            begin
                put(2'b00, 9'h0C3);
                @(negedge clk);
                chk("R10", "ready low while full", int'(wr_ready), 0);
                chk("R11", "done low mid-stream", int'(tx_done), 0);
            end
        join
        run_frame(2'b00, 9'h0C3, "R10");
        @(negedge clk);
        chk("R11", "done after stream", int'(tx_done), 1);
        chk("R10", "ready after stream", int'(wr_ready), 1);

        // random frames
        for (int it = 0; it < 24; it++) begin
            logic [1:0] kind;
            int sel;
            div_val  = 16'($urandom_range(0, 3));
            ovs8     = 1'($urandom_range(0, 1));
            word9    = 1'($urandom_range(0, 1));
            par_en   = 1'($urandom_range(0, 1));
            par_odd  = 1'($urandom_range(0, 1));
            stop_sel = 2'($urandom_range(0, 3));
            sel      = int'($urandom_range(0, 7));
            kind     = (sel == 0) ? 2'b01 : (sel == 1) ? 2'b10 : 2'b00;
            single(kind, 9'($urandom), "R3");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule